// File: doc/BRIEF.md
# Pending Write Register Scoreboard

This block tracks, for every architectural register, whether an instruction already in flight will still write it and how many in-flight instructions still have to read it. Each cycle an issue stage offers one candidate instruction (a destination identifier and two source identifiers with a valid bit). The block answers at once, with no register in the path, whether the candidate would read a value not yet written (RAW), overwrite a result still pending (WAW), or overwrite a value an older instruction has yet to read (WAR). It also reports whether the candidate may issue.

When the candidate issues, its destination is marked reserved and each of its sources gains one pending reader. Two completion ports drop write reservations as results are produced. Two release ports drop one pending reader each as operands are actually read. Register identifier 0 stands for "no register". It is never reserved, never counted, and never flags a hazard. Only identifiers and valid bits pass through the block; no data does.

Top module: `pending_write_scoreboard`

## Requirements
- R1: `haz_raw` is high when `iss_src_a` or `iss_src_b` is nonzero and that register is reserved.
- R2: `haz_waw` is high when `iss_dst` is nonzero and that register is reserved.
- R3: `haz_war` is high when `iss_dst` is nonzero and that register's pending-reader count is nonzero.
- R4: `issue_ok` is high only when `iss_vld` is high, no hazard flag is high, and no nonzero source has a full reader count.
- R5: When `issue_ok` is high, a nonzero `iss_dst` is reserved from the next cycle. Each distinct nonzero source gains one reader; a source named twice gains one.
- R6: A completion port whose valid bit is high (bit p of `cpl_vld`, identifier in bits p*5 upward of `cpl_id`) clears that register's reservation from the next cycle. Both ports can act in one cycle.
- R7: A release port whose valid bit is high (bit p of `rls_vld`, identifier in bits p*5 upward of `rls_id`) lowers that register's reader count by one from the next cycle. A count of zero stays at zero.
- R8: When a completion and an issue name the same register in one cycle, the register stays reserved. When a release and an issue source name the same register in one cycle, its count is unchanged.
- R9: Register 0 is never reserved, never counted, and never raises a hazard flag.
- R10: Without `issue_ok`, whether from a low valid bit or a hazard, no reservation is set and no count rises.
- R11: A synchronous reset clears every reservation and every count.
- R12: The reader count saturates at 7. A candidate whose nonzero source has count 7 gets `issue_ok` low while all three hazard flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_vld | input | 1 | Candidate instruction is present |
| iss_dst | input | 5 | Candidate destination register (0 = none) |
| iss_src_a | input | 5 | Candidate first source register (0 = none) |
| iss_src_b | input | 5 | Candidate second source register (0 = none) |
| cpl_vld | input | 2 | Completion port valid bits |
| cpl_id | input | 10 | Completion register identifiers, 5 bits per port |
| rls_vld | input | 2 | Read-release port valid bits |
| rls_id | input | 10 | Read-release register identifiers, 5 bits per port |
| haz_raw | output | 1 | Read-after-write hazard for the candidate |
| haz_waw | output | 1 | Write-after-write hazard for the candidate |
| haz_war | output | 1 | Write-after-read hazard for the candidate |
| issue_ok | output | 1 | Candidate issues this cycle |

## Verification
Two updates can meet in one cycle: a completion can clear the register that an issuing instruction reserves, and a release can lower the count that an issuing source raises. The bench drives both in a single cycle with matching identifiers. It then judges the merged result on the next cycle from the ports. A follower reading the completed register must still see RAW. A follower writing the released register must still see WAR, and it must see WAR clear only after one further release.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef struct packed {
        logic raw;
        logic waw;
        logic war;
    } sb_haz_t;
endpackage

// File: rtl/sb_write_set.sv
module sb_write_set #(
    parameter int NUM_REGS = 32,
    parameter int ID_W     = $clog2(NUM_REGS),
    parameter int NUM_CPL  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    set_en,
    input  logic [ID_W-1:0]         set_id,
    input  logic [NUM_CPL-1:0]      clr_vld,
    input  logic [NUM_CPL*ID_W-1:0] clr_id,
    output logic [NUM_REGS-1:0]     busy_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0] busy;
    } ws_state_t;

    ws_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_CPL; p++) begin
            if (clr_vld[p]) st_d.busy[clr_id[p*ID_W +: ID_W]] = 1'b0;
        end
        // issue wins over a same-cycle completion
        if (set_en && set_id != '0) st_d.busy[set_id] = 1'b1;
        st_d.busy[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o = st_q.busy;

    a_r5_dst_reserved: assert property (@(posedge clk) disable iff (rst)
        (set_en && set_id != '0) |=> busy_o[$past(set_id)]);

    a_r6_port0_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_vld[0] && !(set_en && set_id == clr_id[ID_W-1:0]))
        |=> !busy_o[$past(clr_id[ID_W-1:0])]);

    a_r9_zero_never_busy: assert property (@(posedge clk) disable iff (rst)
        !busy_o[0]);
endmodule

// File: rtl/sb_read_count.sv
module sb_read_count #(
    parameter int NUM_REGS = 32,
    parameter int ID_W     = $clog2(NUM_REGS),
    parameter int CNT_W    = 3,
    parameter int NUM_REL  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    inc_en,
    input  logic [ID_W-1:0]         inc_a,
    input  logic [ID_W-1:0]         inc_b,
    input  logic [NUM_REL-1:0]      dec_vld,
    input  logic [NUM_REL*ID_W-1:0] dec_id,
    output logic [NUM_REGS-1:0]     nz_o,
    output logic [NUM_REGS-1:0]     full_o
);
    localparam int EXT_W = CNT_W + 2;
    localparam logic [EXT_W-1:0] CNT_MAX = EXT_W'((1 << CNT_W) - 1);

    typedef struct packed {
        logic [NUM_REGS-1:0][CNT_W-1:0] cnt;
    } rc_state_t;

    rc_state_t st_d, st_q;

    always_comb begin
        logic [EXT_W-1:0] val;
        logic [EXT_W-1:0] down;
        logic             up;
        st_d = st_q;
        for (int r = 1; r < NUM_REGS; r++) begin
            up   = inc_en && (inc_a == ID_W'(r) || inc_b == ID_W'(r));
            down = '0;
            for (int p = 0; p < NUM_REL; p++) begin
                if (dec_vld[p] && dec_id[p*ID_W +: ID_W] == ID_W'(r)) down = down + 1'b1;
            end
            val = {2'b00, st_q.cnt[r]} + {{(EXT_W-1){1'b0}}, up};
            if (val >= down) val = val - down;
            else             val = '0;
            if (val > CNT_MAX) val = CNT_MAX;
            st_d.cnt[r] = val[CNT_W-1:0];
        end
        st_d.cnt[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flags
        assign nz_o[g]   = (st_q.cnt[g] != '0);
        assign full_o[g] = (st_q.cnt[g] == '1);
    end

    a_r7_port0_drops: assert property (@(posedge clk) disable iff (rst)
        (dec_vld[0] && dec_id[ID_W-1:0] != '0 && !nz_o[dec_id[ID_W-1:0]] && !inc_en)
        |=> !nz_o[$past(dec_id[ID_W-1:0])]);

    a_r9_zero_never_counted: assert property (@(posedge clk) disable iff (rst)
        !nz_o[0]);
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int ID_W     = $clog2(NUM_REGS)
) (
    input  logic                vld,
    input  logic [ID_W-1:0]     dst,
    input  logic [ID_W-1:0]     src_a,
    input  logic [ID_W-1:0]     src_b,
    input  logic [NUM_REGS-1:0] busy,
    input  logic [NUM_REGS-1:0] rd_nz,
    input  logic [NUM_REGS-1:0] rd_full,
    output sb_haz_t             haz,
    output logic                go
);
    logic a_live, b_live, d_live, full_blk;

    always_comb begin
        a_live   = (src_a != '0);
        b_live   = (src_b != '0);
        d_live   = (dst != '0);
        haz.raw  = (a_live && busy[src_a]) || (b_live && busy[src_b]);
        haz.waw  = d_live && busy[dst];
        haz.war  = d_live && rd_nz[dst];
        full_blk = (a_live && rd_full[src_a]) || (b_live && rd_full[src_b]);
        go       = vld && !haz.raw && !haz.waw && !haz.war && !full_blk;
    end
endmodule

// File: rtl/pending_write_scoreboard.sv
module pending_write_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int ID_W     = $clog2(NUM_REGS),
    parameter int CNT_W    = 3,
    parameter int NUM_CPL  = 2,
    parameter int NUM_REL  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    iss_vld,
    input  logic [ID_W-1:0]         iss_dst,
    input  logic [ID_W-1:0]         iss_src_a,
    input  logic [ID_W-1:0]         iss_src_b,
    input  logic [NUM_CPL-1:0]      cpl_vld,
    input  logic [NUM_CPL*ID_W-1:0] cpl_id,
    input  logic [NUM_REL-1:0]      rls_vld,
    input  logic [NUM_REL*ID_W-1:0] rls_id,
    output logic                    haz_raw,
    output logic                    haz_waw,
    output logic                    haz_war,
    output logic                    issue_ok
);
    logic [NUM_REGS-1:0] busy, rd_nz, rd_full;
    sb_haz_t             haz;
    logic                go;

    sb_write_set #(.NUM_REGS(NUM_REGS), .ID_W(ID_W), .NUM_CPL(NUM_CPL)) u_wset (
        .clk(clk), .rst(rst), .set_en(go), .set_id(iss_dst),
        .clr_vld(cpl_vld), .clr_id(cpl_id), .busy_o(busy)
    );

    sb_read_count #(.NUM_REGS(NUM_REGS), .ID_W(ID_W), .CNT_W(CNT_W), .NUM_REL(NUM_REL)) u_rcnt (
        .clk(clk), .rst(rst), .inc_en(go), .inc_a(iss_src_a), .inc_b(iss_src_b),
        .dec_vld(rls_vld), .dec_id(rls_id), .nz_o(rd_nz), .full_o(rd_full)
    );

    sb_hazard_check #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_hchk (
        .vld(iss_vld), .dst(iss_dst), .src_a(iss_src_a), .src_b(iss_src_b),
        .busy(busy), .rd_nz(rd_nz), .rd_full(rd_full), .haz(haz), .go(go)
    );

    assign haz_raw  = haz.raw;
    assign haz_waw  = haz.waw;
    assign haz_war  = haz.war;
    assign issue_ok = go;

    a_r4_ok_needs_valid: assert property (@(posedge clk) disable iff (rst)
        issue_ok |-> iss_vld);

    a_r4_ok_means_clean: assert property (@(posedge clk) disable iff (rst)
        issue_ok |-> !(haz_raw || haz_waw || haz_war));

    a_r10_no_set_when_held: assert property (@(posedge clk) disable iff (rst)
        (!issue_ok && cpl_vld == '0) |=> $stable(busy));

    a_r12_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (iss_src_a != '0 && rd_full[iss_src_a]) |-> !issue_ok);
endmodule

// File: tb/test_pending_write_scoreboard.sv
module test_pending_write_scoreboard;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_vld = 1'b0;
    logic [4:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic [1:0] cpl_vld = '0, rls_vld = '0;
    logic [9:0] cpl_id = '0, rls_id = '0;
    logic       haz_raw, haz_waw, haz_war, issue_ok;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pending_write_scoreboard i_pending_write_scoreboard (
        .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .cpl_vld(cpl_vld),
        .cpl_id(cpl_id), .rls_vld(rls_vld), .rls_id(rls_id),
        .haz_raw(haz_raw), .haz_waw(haz_waw), .haz_war(haz_war), .issue_ok(issue_ok)
    );

    typedef struct packed {
        logic [0:0] v;  logic [4:0] d;  logic [4:0] a;  logic [4:0] b;
        logic [1:0] cv; logic [4:0] c0; logic [4:0] c1;
        logic [1:0] rv; logic [4:0] r0; logic [4:0] r1;
        logic [3:0] exp;  // raw, waw, war, ok
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1, 1, 2, 3,  0, 0, 0,  0, 0, 0,  4'b0001},  // R11 clean start, R5 reserve 1
        '{1, 4, 1, 0,  0, 0, 0,  0, 0, 0,  4'b1000},  // R1
        '{1, 1, 5, 5,  0, 0, 0,  0, 0, 0,  4'b0100},  // R2
        '{1, 2, 0, 0,  0, 0, 0,  0, 0, 0,  4'b0010},  // R3
        '{0, 6, 7, 7,  0, 0, 0,  0, 0, 0,  4'b0000},  // R10 valid low
        '{1, 8, 6, 0,  0, 0, 0,  0, 0, 0,  4'b0001},  // R10 reg 6 untouched
        '{1, 9, 1, 0,  1, 1, 0,  0, 0, 0,  4'b1000},  // R6 complete 1 on port 0
        '{1, 9, 1, 8,  2, 0, 8,  0, 0, 0,  4'b1000},  // R6 complete 8 on port 1
        '{1, 9, 1, 8,  0, 0, 0,  0, 0, 0,  4'b0001},  // R6 both cleared
        '{1, 3, 0, 0,  0, 0, 0,  3, 2, 3,  4'b0010},  // R7 release 2 and 3
        '{1, 3, 0, 0,  0, 0, 0,  0, 0, 0,  4'b0001},  // R7 count 3 dropped
        '{1, 0, 0, 0,  0, 0, 0,  0, 0, 0,  4'b0001},  // R9
        '{1,10, 0, 0,  1,10, 0,  0, 0, 0,  4'b0001},  // R8 complete+issue reg 10
        '{1,11,10, 0,  0, 0, 0,  0, 0, 0,  4'b1000},  // R8 reg 10 stays reserved
        '{1,12, 1, 0,  0, 0, 0,  1, 1, 0,  4'b0001},  // R8 release+read reg 1
        '{1, 1, 0, 0,  0, 0, 0,  0, 0, 0,  4'b0010},  // R8 count of 1 unchanged
        '{0, 0, 0, 0,  0, 0, 0,  1, 1, 0,  4'b0000},  // R7 last reader of 1
        '{1, 1, 0, 0,  0, 0, 0,  0, 0, 0,  4'b0001},  // R7 reg 1 free of readers
        '{0, 0, 0, 0,  0, 0, 0,  3,13,13,  4'b0000},  // R7 release at zero
        '{1,13, 0, 0,  0, 0, 0,  0, 0, 0,  4'b0001}   // R7 no wrap below zero
    };

    task automatic drive(input vec_t t);
        iss_vld = t.v; iss_dst = t.d; iss_src_a = t.a; iss_src_b = t.b;
        cpl_vld = t.cv; cpl_id = {t.c1, t.c0};
        rls_vld = t.rv; rls_id = {t.r1, t.r0};
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] got;
        #1;
        got = {haz_raw, haz_waw, haz_war, issue_ok};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: flags raw/waw/war/ok got %b expected %b", req, got, exp);
        end
    endtask

    task automatic one(input string req, input logic v, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b,
                       input logic [1:0] rv, input logic [4:0] r0, input logic [3:0] exp);
        vec_t t;
        t = '0;
        t.v = v; t.d = d; t.a = a; t.b = b; t.rv = rv; t.r0 = r0;
        @(negedge clk);
        drive(t);
        check(req, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            check($sformatf("row %0d", i), TBL[i].exp);
        end

        // R11 reset clears state built above (reg 13 reserved, reg 12 reserved)
        @(negedge clk); drive('0); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        one("R11 reserve cleared", 1, 13, 12, 0, 0, 0, 4'b0001);

        // R12 fill reader count of reg 20 to 7
        @(negedge clk); drive('0); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int k = 0; k < 7; k++) one("R12 fill", 1, 0, 20, 20, 0, 0, 4'b0001);
        one("R12 full blocks", 1, 0, 20, 0, 0, 0, 4'b0000);
        one("R12 full blocks src b", 1, 0, 0, 20, 1, 20, 4'b0000);
        one("R12 after release", 1, 0, 20, 0, 0, 0, 4'b0001);
        one("R3 count at 7", 1, 20, 0, 0, 0, 0, 4'b0010);

        // R11 reset clears counts
        @(negedge clk); drive('0); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        one("R11 count cleared", 1, 20, 0, 0, 0, 0, 4'b0001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule